// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Address Decode

This unit reads an instruction stream from a byte-addressed memory with 20-bit addresses, one byte per clock, and finds each instruction's length as its bytes arrive. The first byte is compared against a fixed table of short opcodes, which are one or two bytes long. For any other opcode the second byte carries a flag nibble, and the extend flag in that nibble chooses between a three-byte form with a 12-bit displacement and a four-byte form with a 20-bit address field.

When the last byte of an instruction has been read, the unit splits out the opcode, the register nibbles, the six addressing flags and the raw displacement or address field. For three- and four-byte instructions it also computes the target address. The base and index registers come in as inputs. The unit presents everything on registered outputs together with a one-cycle valid strobe.

The fetch pointer never stalls. The memory port is combinational: `mem_rdata` must show the byte at `mem_addr` within the same cycle. The next instruction's opcode byte is read in the cycle right after the last byte of the current one.

Top module: `ivd_fetch_decode`

## Requirements
- R1: While reset is held, `dec_valid` is 0 and `mem_addr` equals the start address, which defaults to 0.
- R2: After reset, `mem_addr` advances by one every cycle. `dec_valid` pulses for one cycle per instruction, in the cycle after the instruction's last byte is read. Consecutive pulses are spaced by the later instruction's length in cycles. `dec_pc` is the address of that instruction's first byte.
- R3: The opcode bytes C0, C4, C8, F0, F4 and F8 (hex) form one-byte instructions. For these, `dec_fmt` is 0 and `dec_opcode` is that byte.
- R4: The opcode bytes 90 to B8 hex in steps of 4 form two-byte instructions with `dec_fmt` = 1. `dec_r1` is the high nibble of the second byte and `dec_r2` is its low nibble.
- R5: Every other first byte starts a memory-operand instruction. `dec_opcode` is that byte with its low two bits cleared. `dec_flags` is {n,i,x,b,p,e}, taken from first-byte bits 1:0 and second-byte bits 7:4. When e is 0 the instruction is three bytes long (`dec_fmt` = 2), and `dec_disp` is the 12-bit value made of the second byte's low nibble followed by the third byte.
- R6: When e is 1 the instruction is four bytes long (`dec_fmt` = 3), and `dec_disp` is the 20-bit value made of the second byte's low nibble followed by bytes three and four.
- R7: In the three-byte form, b=1 and p=0 give a target of `base_reg` plus the displacement, with the displacement taken as unsigned.
- R8: In the three-byte form, b=0 and p=1 give a target of the next instruction's address plus the sign-extended displacement.
- R9: With b=0 and p=0, the target is `dec_disp` itself. This holds for both the three- and the four-byte form.
- R10: When x is 1, `index_reg` is added to the target. All sums wrap modulo 2^20.
- R11: `dec_illegal` is set when b and p are both 1 in the three-byte form, or when either is 1 in the four-byte form. When it is set, `dec_target` is 0.
- R12: For one- and two-byte instructions, `dec_flags`, `dec_target` and `dec_illegal` are 0. `dec_disp` is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| mem_addr | output | 20 | Address of the byte being read this cycle |
| mem_rdata | input | 8 | Byte at `mem_addr`, valid in the same cycle |
| base_reg | input | 20 | Base register value for base-relative targets |
| index_reg | input | 20 | Index register value added when x is set |
| dec_valid | output | 1 | One-cycle strobe: the decoded fields below are new |
| dec_fmt | output | 2 | Instruction length minus one |
| dec_pc | output | 20 | Address of the instruction's first byte |
| dec_opcode | output | 8 | Opcode, with n/i bits cleared for memory-operand forms |
| dec_r1 | output | 4 | First register number of two-byte forms |
| dec_r2 | output | 4 | Second register number of two-byte forms |
| dec_flags | output | 6 | {n,i,x,b,p,e} |
| dec_disp | output | 20 | Raw displacement or address field, zero-extended |
| dec_target | output | 20 | Computed target address |
| dec_illegal | output | 1 | Forbidden b/p combination seen |

## Verification
If the byte-slot state goes wrong, the instruction boundaries slip. The very next strobe then arrives after the wrong number of cycles and carries a start address that no longer matches the running sum of lengths. Every strobe after that also decodes a shifted byte stream, so the fault shows within one instruction and keeps showing. A wrong target-mode select or a wrong sign extension shows only in `dec_target` on the strobe of an affected instruction. The stream therefore mixes every b/p/x combination and places directed negative displacements and sums that wrap past 2^20.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  localparam int ADDR_W    = 20;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 4;
  localparam int REG_W     = 4;
  localparam int NEAR_W    = 12;
  localparam int FLAG_W    = 6;
  // bit of the second byte that selects the four-byte form
  localparam int EXT_BIT   = 4;
  // positions inside the flag vector {n,i,x,b,p,e}
  localparam int FL_X      = 3;
  localparam int FL_B      = 2;
  localparam int FL_P      = 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    FMT_1B = 2'd0,
    FMT_2B = 2'd1,
    FMT_3B = 2'd2,
    FMT_4B = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    SLOT_0 = 2'd0,
    SLOT_1 = 2'd1,
    SLOT_2 = 2'd2,
    SLOT_3 = 2'd3
  } slot_e;

  typedef struct packed {
    fmt_e                 fmt;
    addr_t                pc;
    byte_t                opcode;
    logic [REG_W-1:0]     r1;
    logic [REG_W-1:0]     r2;
    logic [FLAG_W-1:0]    flags;
    addr_t                field;
    addr_t                target;
    logic                 illegal;
  } dec_out_t;

  // one-byte opcodes: fixed table
  function automatic logic op_is_1b(byte_t op);
    case (op)
      8'hC0, 8'hC4, 8'hC8, 8'hF0, 8'hF4, 8'hF8: return 1'b1;
      default:                                   return 1'b0;
    endcase
  endfunction

  // two-byte opcodes: 0x90 .. 0xB8, word aligned
  function automatic logic op_is_2b(byte_t op);
    return (op[1:0] == 2'b00) && (op >= 8'h90) && (op <= 8'hB8);
  endfunction
endpackage

// File: rtl/ivd_byte_seq.sv
module ivd_byte_seq
  import ivd_pkg::*;
#(
  parameter addr_t START_PC = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  byte_t                           mem_rdata,
  output addr_t                           mem_addr,
  output logic [MAX_BYTES-1:0][BYTE_W-1:0] ins_bytes,
  output logic                            fire,
  output fmt_e                            fire_fmt,
  output addr_t                           ins_pc,
  output addr_t                           next_pc
);
  slot_e slot_q, slot_d;
  addr_t addr_q, addr_d;
  addr_t pc_q, pc_d;
  logic [MAX_BYTES-1:0][BYTE_W-1:0] hold_q;

  // length decision as bytes arrive
  always_comb begin
    fire     = 1'b0;
    fire_fmt = FMT_1B;
    slot_d   = slot_q;
    unique case (slot_q)
      SLOT_0: begin
        if (op_is_1b(mem_rdata)) begin
          fire     = 1'b1;
          fire_fmt = FMT_1B;
        end else begin
          slot_d = SLOT_1;
        end
      end
      SLOT_1: begin
        if (op_is_2b(hold_q[0])) begin
          fire     = 1'b1;
          fire_fmt = FMT_2B;
          slot_d   = SLOT_0;
        end else begin
          slot_d = SLOT_2;
        end
      end
      SLOT_2: begin
        if (!hold_q[1][EXT_BIT]) begin
          fire     = 1'b1;
          fire_fmt = FMT_3B;
          slot_d   = SLOT_0;
        end else begin
          slot_d = SLOT_3;
        end
      end
      SLOT_3: begin
        fire     = 1'b1;
        fire_fmt = FMT_4B;
        slot_d   = SLOT_0;
      end
      default: slot_d = SLOT_0;
    endcase
  end

  always_comb begin
    addr_d = addr_q + ADDR_W'(1);
    pc_d   = (slot_q == SLOT_0) ? addr_q : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_0;
      addr_q <= START_PC;
      pc_q   <= START_PC;
    end else begin
      slot_q <= slot_d;
      addr_q <= addr_d;
      pc_q   <= pc_d;
    end
  end

  // per-slot byte capture; the current slot sees the live byte
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[k] <= '0;
      end else if (slot_q == slot_e'(k)) begin
        hold_q[k] <= mem_rdata;
      end
    end
    assign ins_bytes[k] = (slot_q == slot_e'(k)) ? mem_rdata : hold_q[k];
  end

  assign mem_addr = addr_q;
  assign ins_pc   = pc_d;
  assign next_pc  = addr_d;
endmodule

// File: rtl/ivd_field_split.sv
module ivd_field_split
  import ivd_pkg::*;
(
  input  fmt_e                             fmt,
  input  logic [MAX_BYTES-1:0][BYTE_W-1:0] ins_bytes,
  output byte_t                            opcode,
  output logic [REG_W-1:0]                 r1,
  output logic [REG_W-1:0]                 r2,
  output logic [FLAG_W-1:0]                flags,
  output addr_t                            field
);
  always_comb begin
    opcode = ins_bytes[0];
    r1     = '0;
    r2     = '0;
    flags  = '0;
    field  = '0;
    unique case (fmt)
      FMT_1B: ;
      FMT_2B: begin
        r1 = ins_bytes[1][BYTE_W-1:REG_W];
        r2 = ins_bytes[1][REG_W-1:0];
      end
      FMT_3B, FMT_4B: begin
        opcode = {ins_bytes[0][BYTE_W-1:2], 2'b00};
        flags  = {ins_bytes[0][1:0], ins_bytes[1][BYTE_W-1:REG_W]};
        if (fmt == FMT_3B)
          field = ADDR_W'({ins_bytes[1][REG_W-1:0], ins_bytes[2]});
        else
          field = ADDR_W'({ins_bytes[1][REG_W-1:0], ins_bytes[2], ins_bytes[3]});
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ivd_target_gen.sv
module ivd_target_gen
  import ivd_pkg::*;
(
  input  fmt_e              fmt,
  input  logic [FLAG_W-1:0] flags,
  input  addr_t             field,
  input  addr_t             base_reg,
  input  addr_t             index_reg,
  input  addr_t             next_pc,
  output addr_t             target,
  output logic              illegal
);
  logic              mem_op;
  logic              long_form;
  logic [NEAR_W-1:0] near;
  addr_t             pre_idx;
  addr_t             with_idx;

  always_comb begin
    mem_op    = (fmt == FMT_3B) || (fmt == FMT_4B);
    long_form = (fmt == FMT_4B);
    near      = field[NEAR_W-1:0];
    illegal   = mem_op && (long_form ? (flags[FL_B] | flags[FL_P])
                                     : (flags[FL_B] & flags[FL_P]));
    unique case ({flags[FL_B], flags[FL_P]})
      2'b10:   pre_idx = base_reg + ADDR_W'(near);
      2'b01:   pre_idx = next_pc + ADDR_W'($signed(near));
      default: pre_idx = field;
    endcase
    with_idx = flags[FL_X] ? (pre_idx + index_reg) : pre_idx;
    target   = (mem_op && !illegal) ? with_idx : '0;
  end
endmodule

// File: rtl/ivd_fetch_decode.sv
module ivd_fetch_decode
  import ivd_pkg::*;
#(
  parameter addr_t START_PC    = '0,
  parameter int    SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic [BYTE_W-1:0]    mem_rdata,
  input  logic [ADDR_W-1:0]    base_reg,
  input  logic [ADDR_W-1:0]    index_reg,
  output logic                 dec_valid,
  output logic [1:0]           dec_fmt,
  output logic [ADDR_W-1:0]    dec_pc,
  output logic [BYTE_W-1:0]    dec_opcode,
  output logic [REG_W-1:0]     dec_r1,
  output logic [REG_W-1:0]     dec_r2,
  output logic [FLAG_W-1:0]    dec_flags,
  output logic [ADDR_W-1:0]    dec_disp,
  output logic [ADDR_W-1:0]    dec_target,
  output logic                 dec_illegal
);
  // reset: asserted at once, released on a clock edge
  logic rst_core_n;
  logic [SYNC_STAGES-1:0] sync_q;
  if (SYNC_STAGES > 1) begin : g_sync_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end else begin : g_sync_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= 1'b1;
    end
  end
  assign rst_core_n = sync_q[SYNC_STAGES-1];

  logic [MAX_BYTES-1:0][BYTE_W-1:0] ins_bytes;
  logic              fire;
  fmt_e              fire_fmt;
  addr_t             ins_pc, next_pc;
  byte_t             sp_opcode;
  logic [REG_W-1:0]  sp_r1, sp_r2;
  logic [FLAG_W-1:0] sp_flags;
  addr_t             sp_field, tg_target;
  logic              tg_illegal;

  ivd_byte_seq #(.START_PC(START_PC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .ins_bytes (ins_bytes),
    .fire      (fire),
    .fire_fmt  (fire_fmt),
    .ins_pc    (ins_pc),
    .next_pc   (next_pc)
  );

  ivd_field_split u_split (
    .fmt       (fire_fmt),
    .ins_bytes (ins_bytes),
    .opcode    (sp_opcode),
    .r1        (sp_r1),
    .r2        (sp_r2),
    .flags     (sp_flags),
    .field     (sp_field)
  );

  ivd_target_gen u_tgt (
    .fmt       (fire_fmt),
    .flags     (sp_flags),
    .field     (sp_field),
    .base_reg  (base_reg),
    .index_reg (index_reg),
    .next_pc   (next_pc),
    .target    (tg_target),
    .illegal   (tg_illegal)
  );

  dec_out_t out_q, out_d;
  logic     valid_q, valid_d;

  always_comb begin
    valid_d = fire;
    out_d   = out_q;
    if (fire) begin
      out_d.fmt     = fire_fmt;
      out_d.pc      = ins_pc;
      out_d.opcode  = sp_opcode;
      out_d.r1      = sp_r1;
      out_d.r2      = sp_r2;
      out_d.flags   = sp_flags;
      out_d.field   = sp_field;
      out_d.target  = tg_target;
      out_d.illegal = tg_illegal;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      valid_q <= valid_d;
      out_q   <= out_d;
    end
  end

  assign dec_valid   = valid_q;
  assign dec_fmt     = out_q.fmt;
  assign dec_pc      = out_q.pc;
  assign dec_opcode  = out_q.opcode;
  assign dec_r1      = out_q.r1;
  assign dec_r2      = out_q.r2;
  assign dec_flags   = out_q.flags;
  assign dec_disp    = out_q.field;
  assign dec_target  = out_q.target;
  assign dec_illegal = out_q.illegal;
endmodule

// File: rtl/ivd_fetch_chk.sv
module ivd_fetch_chk
  import ivd_pkg::*;
(
  input logic              clk,
  input logic              rst_core_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              dec_valid,
  input logic [1:0]        dec_fmt,
  input logic [ADDR_W-1:0] dec_pc,
  input logic [FLAG_W-1:0] dec_flags,
  input logic [ADDR_W-1:0] dec_disp,
  input logic [ADDR_W-1:0] dec_target,
  input logic              dec_illegal
);
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    1'b1 |=> mem_addr == $past(mem_addr) + ADDR_W'(1)); // R2

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_core_n)
    dec_valid |-> mem_addr == dec_pc + ADDR_W'(dec_fmt) + ADDR_W'(1)); // R2

  AST_SHORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dec_valid && !dec_fmt[1]) |-> (dec_flags == '0 && dec_target == '0 && !dec_illegal)); // R12

  AST_LEN_THREE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dec_valid && dec_fmt == 2'd2) |-> !dec_flags[0]); // R5

  AST_LEN_FOUR: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dec_valid && dec_fmt == 2'd3) |-> dec_flags[0]); // R6

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dec_valid && dec_illegal) |-> dec_target == '0); // R11

  AST_DIRECT_FIELD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dec_valid && dec_fmt[1] && dec_flags[3:1] == 3'b000) |-> dec_target == dec_disp); // R9
endmodule

bind ivd_fetch_decode ivd_fetch_chk u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .mem_addr    (mem_addr),
  .dec_valid   (dec_valid),
  .dec_fmt     (dec_fmt),
  .dec_pc      (dec_pc),
  .dec_flags   (dec_flags),
  .dec_disp    (dec_disp),
  .dec_target  (dec_target),
  .dec_illegal (dec_illegal)
);

// File: tb/ivd_fetch_decode_tb_top.sv
`timescale 1ns/1ps
module ivd_fetch_decode_tb_top;
  localparam int N_INSTR = 300;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [19:0] base_reg, index_reg;
  logic        dec_valid, dec_illegal;
  logic [1:0]  dec_fmt;
  logic [19:0] dec_pc, dec_disp, dec_target;
  logic [7:0]  dec_opcode;
  logic [3:0]  dec_r1, dec_r2;
  logic [5:0]  dec_flags;

  logic [7:0] tb_mem [0:4095];
  assign mem_rdata = tb_mem[mem_addr[11:0]];

  always #2 clk = ~clk;

  ivd_fetch_decode dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .base_reg(base_reg), .index_reg(index_reg), .dec_valid(dec_valid),
    .dec_fmt(dec_fmt), .dec_pc(dec_pc), .dec_opcode(dec_opcode),
    .dec_r1(dec_r1), .dec_r2(dec_r2), .dec_flags(dec_flags),
    .dec_disp(dec_disp), .dec_target(dec_target), .dec_illegal(dec_illegal)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int pos = 0;
  int gen_cnt = 0;
  int gap, icount;
  bit first, mon_en = 1'b0;
  logic [19:0] exp_pc;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [7:0]  op;
    logic [3:0]  r1;
    logic [3:0]  r2;
    logic [5:0]  fl;
    logic [19:0] fld;
    logic [19:0] tgt;
    logic        ill;
  } exp_t;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit tb_one(input logic [7:0] b);
    return b inside {8'hC0, 8'hC4, 8'hC8, 8'hF0, 8'hF4, 8'hF8};
  endfunction

  function automatic bit tb_two(input logic [7:0] b);
    return b inside {8'h90, 8'h94, 8'h98, 8'h9C, 8'hA0, 8'hA4,
                     8'hA8, 8'hAC, 8'hB0, 8'hB4, 8'hB8};
  endfunction

  function automatic exp_t ref_dec(input logic [19:0] pc);
    exp_t e;
    logic [7:0]  c0, c1, c2, c3;
    logic [19:0] a1, a2, a3, np, t;
    logic [11:0] d;
    e  = '0;
    a1 = pc + 20'd1; a2 = pc + 20'd2; a3 = pc + 20'd3;
    c0 = tb_mem[pc[11:0]]; c1 = tb_mem[a1[11:0]];
    c2 = tb_mem[a2[11:0]]; c3 = tb_mem[a3[11:0]];
    if (tb_one(c0))      e.fmt = 2'd0;
    else if (tb_two(c0)) e.fmt = 2'd1;
    else                 e.fmt = c1[4] ? 2'd3 : 2'd2;
    np = pc + 20'(e.fmt) + 20'd1;
    e.op = c0;
    if (e.fmt == 2'd1) begin
      e.r1 = c1[7:4];
      e.r2 = c1[3:0];
    end else if (e.fmt[1]) begin
      e.op  = {c0[7:2], 2'b00};
      e.fl  = {c0[1:0], c1[7:4]};
      d     = {c1[3:0], c2};
      e.fld = (e.fmt == 2'd3) ? {c1[3:0], c2, c3} : {8'h00, d};
      if (e.fmt == 2'd2) begin
        e.ill = c1[6] & c1[5];
        if (c1[6])      t = base_reg + {8'h00, d};
        else if (c1[5]) t = np + {{8{d[11]}}, d};
        else            t = e.fld;
      end else begin
        e.ill = c1[6] | c1[5];
        t = e.fld;
      end
      if (c1[7]) t = t + index_reg;
      e.tgt = e.ill ? 20'h0 : t;
    end
    return e;
  endfunction

  // monitor: every strobe compared against the reference walk of memory
  exp_t ex;
  int   len;
  string ftag, ttag;
  always @(negedge clk) begin
    if (!mon_en) begin
      gap = 0; first = 1'b1; exp_pc = 20'h0; icount = 0;
    end else begin
      gap++;
      if (dec_valid) begin
        ex  = ref_dec(exp_pc);
        len = int'(ex.fmt) + 1;
        case (ex.fmt)
          2'd0: ftag = "R3";
          2'd1: ftag = "R4";
          2'd2: ftag = "R5";
          default: ftag = "R6";
        endcase
        if (!ex.fmt[1])        ttag = "R12";
        else if (ex.ill)       ttag = "R11";
        else if (ex.fl[3])     ttag = "R10";
        else if (ex.fl[2])     ttag = "R7";
        else if (ex.fl[1])     ttag = "R8";
        else                   ttag = "R9";
        if (!first) chk(gap == len, "R2 strobe spacing", gap, len);
        chk(dec_pc == exp_pc, "R2 start address", dec_pc, exp_pc);
        chk(dec_fmt == ex.fmt, {ftag, " format"}, dec_fmt, ex.fmt);
        chk(dec_opcode == ex.op, {ftag, " opcode"}, dec_opcode, ex.op);
        chk({dec_r1, dec_r2} == {ex.r1, ex.r2}, "R4 register nibbles", {dec_r1, dec_r2}, {ex.r1, ex.r2});
        chk(dec_flags == ex.fl, "R5 flags", dec_flags, ex.fl);
        chk(dec_disp == ex.fld, {ftag, " field"}, dec_disp, ex.fld);
        chk(dec_illegal == ex.ill, "R11 illegal flag", dec_illegal, ex.ill);
        chk(dec_target == ex.tgt, {ttag, " target"}, dec_target, ex.tgt);
        exp_pc = exp_pc + 20'(len);
        gap = 0;
        first = 1'b0;
        icount++;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog: decoded act=%0d exp=%0d", icount, N_INSTR);
      summary();
      $finish;
    end
  end

  task automatic put(input logic [7:0] b);
    tb_mem[pos] = b;
    pos++;
  endtask

  task automatic put_ins(input logic [31:0] w, input int n);
    for (int k = n - 1; k >= 0; k--) put(w[8*k +: 8]);
    gen_cnt++;
  endtask

  task automatic fill_memory();
    logic [7:0] f1 [6];
    logic [7:0] f2 [11];
    int cat;
    logic [7:0] b0, b1;
    f1 = '{8'hC0, 8'hC4, 8'hC8, 8'hF0, 8'hF4, 8'hF8};
    f2 = '{8'h90, 8'h94, 8'h98, 8'h9C, 8'hA0, 8'hA4, 8'hA8, 8'hAC, 8'hB0, 8'hB4, 8'hB8};
    for (int i = 0; i < 4096; i++) tb_mem[i] = 8'h00;
    pos = 0; gen_cnt = 0;
    // directed corners
    put_ins(32'hC4, 1);           // R3 short opcode
    put_ins(32'hF8, 1);           // R3 last table entry
    put_ins(32'h983C, 2);         // R4 nibbles
    put_ins(32'h90FF, 2);         // R4 first table entry
    put_ins(32'h032FF0, 3);       // R8 negative PC-relative
    put_ins(32'h4B4AFF, 3);       // R7 base-relative, wraps with high base
    put_ins(32'hC1954321, 4);     // R6 table neighbour is long form, R10 index
    put_ins(32'h076000, 3);       // R11 b and p both set
    put_ins(32'h0B312345, 4);     // R11 p set in long form
    put_ins(32'h138765, 3);       // R9 direct plus R10 index
    put_ins(32'hC50010, 3);       // R5 table neighbour is three bytes
    put_ins(32'hB92005, 3);       // R8 forward PC-relative
    while (gen_cnt < N_INSTR + 10) begin
      cat = int'($urandom_range(0, 3));
      case (cat)
        0: put_ins({24'h0, f1[$urandom_range(0, 5)]}, 1);
        1: put_ins({16'h0, f2[$urandom_range(0, 10)], 8'($urandom)}, 2);
        default: begin
          b0 = {2'b00, 6'($urandom)};
          b1 = 8'($urandom);
          b1[4] = (cat == 3);
          if (cat == 3) put_ins({b0, b1, 16'($urandom)}, 4);
          else          put_ins({8'h0, b0, b1, 8'($urandom)}, 3);
        end
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    base_reg = 20'h0; index_reg = 20'h0;
    for (int phase = 0; phase < 2; phase++) begin
      rst_n  = 1'b0;
      mon_en = 1'b0;
      base_reg  = (phase == 0) ? 20'hFFF00 : 20'h12345;
      index_reg = (phase == 0) ? 20'h00123 : 20'hFFFF0;
      fill_memory();
      repeat (4) @(negedge clk);
      chk(dec_valid == 1'b0, "R1 valid in reset", dec_valid, 0);
      chk(mem_addr == 20'h0, "R1 fetch address in reset", mem_addr, 0);
      #1;
      mon_en = 1'b1;
      rst_n  = 1'b1;
      wait (icount >= N_INSTR);
      @(negedge clk);
    end
    summary();
    $finish;
  end
endmodule